// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

The block scans a key matrix of up to eight rows by eight columns. One side of the matrix is driven, one line at a time, with an active-low pattern. The other side is sensed through a two-stage synchronizer and an optional per-line glitch filter. At the end of each line's dwell the sensed levels are folded into a 64-bit key-state image. An optional per-key confirmation filter can require the same new value on several consecutive scans before a key's state changes.

Each change of a key's state can set a per-key flag, chosen by that key's two-bit edge selection. The flags are gated by a per-key enable mask into a single interrupt output. Software sets the block up and reads it through a small word-addressed register port. Writes take effect on the clock edge; reads are combinational.

Top module: `kmx_scan_ctrl`

## Requirements
- R1: Registers sit at byte offsets control 0x80, pin direction 0x84, edge selection 0x90/0x94/0x98/0x9C, key state 0xA0/0xA4, flag enable 0xB0/0xB4, flag clear 0xB8/0xBC and flags 0xC0/0xC4. All read 0 after reset. Control reads back only its implemented bits (mask 0x0077FF03), pin direction only bits [31:16], and the clear words read 0.
- R2: Key (r,c) is bit 8*(r%4)+c of key-state word r/4. With any of pin-direction bits [31:24] set, the rows are driven and the columns are sensed.
- R3: With pin-direction bits [31:24] all zero, the columns are driven and the rows are sensed. The key-state image is the same as with rows driven.
- R4: With control bit 1 clear, a key-state bit of 1 means pressed. With control bit 1 set, a key-state bit of 0 means pressed.
- R5: Control bits [22:20] hold the row count minus one and bits [18:16] hold the column count minus one. Keys outside that area keep their previous state.
- R6: At most one driven line is low at any time, and the sensed side stays all high. The row output enables equal pin-direction bits [31:24] and the column output enables equal bits [23:16].
- R7: With control bit 0 (enable) clear, all lines stay high, the key state is frozen and no flag is set.
- R8: Key k=8r+c has its edge selection in edge word k/16, bits [2*(k%16)+1 : 2*(k%16)]. 0 selects nothing, 1 a 0-to-1 state change, 2 a 1-to-0 change and 3 both. A flag sets on a selected change whatever the mask.
- R9: Flag and mask words use the key-state packing. The interrupt output is high exactly when some flag bit and its mask bit are both 1.
- R10: Writing 1s to a clear word clears the matching flag bits. Writing 0 bits leaves flags unchanged.
- R11: Control bit 11 enables the line filter, and bits [10:8] give sel. A sensed level is accepted only after it has been stable for 2^(sel+1) cycles, so a shorter press never reaches the key state.
- R12: Control bit 15 enables the confirmation filter, and bits [14:12] give n. A key's state changes only after the new value has been seen on n+1 consecutive scans of that key.
- R13: Each driven line is held low for SETTLE cycles (default 6) with the line filter off, and for 2^(sel+1)+SETTLE cycles with it on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| row_in | input | 8 | Sensed row pin levels |
| col_in | input | 8 | Sensed column pin levels |
| row_drv_o | output | 8 | Row pin drive values |
| row_oe_o | output | 8 | Row pin output enables |
| col_drv_o | output | 8 | Column pin drive values |
| col_oe_o | output | 8 | Column pin output enables |
| irq_o | output | 1 | Masked key-change interrupt |

## Verification
A wrong line index or dwell counter shows on the drive pins within one dwell, as a second low line or a wrong hold length. A wrong key-state bit shows in the key-state words within one full scan of the active area, which is at most eight dwells. A misdecoded edge selection or mask shows in the flag words and on the interrupt output in that same scan. A broken filter stays hidden until a glitch shorter than its window reaches the key state, so the bench drives such glitches on purpose.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
   localparam logic [7:0] OFS_CTRL  = 8'h80;
   localparam logic [7:0] OFS_PIND  = 8'h84;
   localparam logic [7:0] OFS_EDGE0 = 8'h90;
   localparam logic [7:0] OFS_STAT0 = 8'hA0;
   localparam logic [7:0] OFS_MASK0 = 8'hB0;
   localparam logic [7:0] OFS_CLR0  = 8'hB8;
   localparam logic [7:0] OFS_FLAG0 = 8'hC0;
   localparam logic [31:0] CTRL_IMPL = 32'h0077FF03;
   localparam logic [31:0] PIND_IMPL = 32'hFFFF0000;

   typedef struct packed {
      logic       en;
      logic       pull;
      logic [2:0] nrow_m1;
      logic [2:0] ncol_m1;
      logic       cf_en;
      logic [2:0] cf_sel;
      logic       lf_en;
      logic [2:0] lf_sel;
      logic       rows_drv;
   } kmx_cfg_t;
endpackage

// File: rtl/kmx_regs.sv
module kmx_regs
   import kmx_pkg::*;
#(
   parameter int unsigned KEYS = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [7:0]         addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   input  logic [KEYS-1:0]    status,
   input  logic [KEYS-1:0]    flags,
   output kmx_cfg_t           cfg,
   output logic [2*KEYS-1:0]  edge_sel,
   output logic [KEYS-1:0]    mask,
   output logic [KEYS-1:0]    clr,
   output logic [7:0]         row_oe,
   output logic [7:0]         col_oe
);
   localparam int unsigned SW = KEYS / 32;
   localparam int unsigned EW = 2 * SW;

   logic [31:0] ctrl_q;
   logic [15:0] pind_q;
   logic [31:0] edge_q [EW];
   logic [31:0] mask_q [SW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pind_q <= '0;
         for (int i = 0; i < EW; i++) edge_q[i] <= '0;
         for (int i = 0; i < SW; i++) mask_q[i] <= '0;
      end else if (we) begin
         if (addr == OFS_CTRL) ctrl_q <= wdata & CTRL_IMPL;
         if (addr == OFS_PIND) pind_q <= wdata[31:16];
         for (int i = 0; i < EW; i++)
            if (addr == OFS_EDGE0 + 8'(4 * i)) edge_q[i] <= wdata;
         for (int i = 0; i < SW; i++)
            if (addr == OFS_MASK0 + 8'(4 * i)) mask_q[i] <= wdata;
      end
   end

   for (genvar w = 0; w < SW; w++) begin : g_word
      assign mask[32*w +: 32] = mask_q[w];
      assign clr[32*w +: 32]  = (we && addr == OFS_CLR0 + 8'(4 * w)) ? wdata : 32'd0;
   end
   for (genvar e = 0; e < EW; e++) begin : g_edge
      assign edge_sel[32*e +: 32] = edge_q[e];
   end

   always_comb begin
      rdata = '0;
      if (addr == OFS_CTRL) rdata = ctrl_q;
      if (addr == OFS_PIND) rdata = {pind_q, 16'd0};
      for (int i = 0; i < EW; i++)
         if (addr == OFS_EDGE0 + 8'(4 * i)) rdata = edge_q[i];
      for (int i = 0; i < SW; i++) begin
         if (addr == OFS_STAT0 + 8'(4 * i)) rdata = status[32*i +: 32];
         if (addr == OFS_MASK0 + 8'(4 * i)) rdata = mask_q[i];
         if (addr == OFS_FLAG0 + 8'(4 * i)) rdata = flags[32*i +: 32];
      end
   end

   assign cfg.en       = ctrl_q[0];
   assign cfg.pull     = ctrl_q[1];
   assign cfg.lf_sel   = ctrl_q[10:8];
   assign cfg.lf_en    = ctrl_q[11];
   assign cfg.cf_sel   = ctrl_q[14:12];
   assign cfg.cf_en    = ctrl_q[15];
   assign cfg.ncol_m1  = ctrl_q[18:16];
   assign cfg.nrow_m1  = ctrl_q[22:20];
   assign cfg.rows_drv = |pind_q[15:8];
   assign row_oe       = pind_q[15:8];
   assign col_oe       = pind_q[7:0];
endmodule

// File: rtl/kmx_deglitch.sv
module kmx_deglitch #(
   parameter int unsigned SEL_W = 3,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   input  logic             din,
   output logic             q
);
   if (CNT_W < (1 << SEL_W)) begin : g_bad_cnt
      $error("kmx_deglitch: CNT_W too small for the longest window");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             held_q;

   assign lim = CNT_W'((33'd1 << ({1'b0, sel} + 1'b1)) - 33'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b1;
         cnt_q  <= '0;
      end else if (!en || din == held_q) begin
         held_q <= din;
         cnt_q  <= '0;
      end else if (cnt_q >= lim) begin
         held_q <= din;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign q = en ? held_q : din;
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
   import kmx_pkg::*;
#(
   parameter int unsigned LINES  = 8,
   parameter int unsigned SETTLE = 6,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  kmx_cfg_t                 cfg,
   input  logic [LINES-1:0]         sense,
   input  logic [2*LINES*LINES-1:0] edge_sel,
   input  logic [LINES*LINES-1:0]   clr,
   output logic [LINES-1:0]         row_drv,
   output logic [LINES-1:0]         col_drv,
   output logic [LINES*LINES-1:0]   status,
   output logic [LINES*LINES-1:0]   flags
);
   localparam int unsigned LW     = $clog2(LINES);
   localparam int unsigned HOLD_W = CNT_W + 2;

   logic [LW-1:0]     idx_q;
   logic [HOLD_W-1:0] dw_q;
   logic [HOLD_W-1:0] hold_len;
   logic [LW-1:0]     last_idx;
   logic              latch;
   logic [LINES-1:0]  line_lo;

   assign hold_len = cfg.lf_en
      ? HOLD_W'((33'd1 << ({1'b0, cfg.lf_sel} + 1'b1)) + 33'(SETTLE))
      : HOLD_W'(SETTLE);
   assign last_idx = cfg.rows_drv ? cfg.nrow_m1 : cfg.ncol_m1;
   assign latch    = cfg.en && (dw_q >= hold_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         dw_q  <= '0;
      end else if (!cfg.en) begin
         idx_q <= '0;
         dw_q  <= '0;
      end else if (latch) begin
         dw_q  <= '0;
         idx_q <= (idx_q >= last_idx) ? '0 : idx_q + 1'b1;
      end else begin
         dw_q <= dw_q + 1'b1;
      end
   end

   assign line_lo = cfg.en ? ~(LINES'(1) << idx_q) : '1;
   assign row_drv = cfg.rows_drv ? line_lo : '1;
   assign col_drv = cfg.rows_drv ? '1 : line_lo;

   for (genvar r = 0; r < LINES; r++) begin : g_row
      for (genvar c = 0; c < LINES; c++) begin : g_col
         localparam int unsigned K = r * LINES + c;
         logic       hit, level, nv, commit, seen;
         logic [2:0] cf_q;

         assign hit = latch && (cfg.rows_drv
            ? (idx_q == LW'(r) && LW'(c) <= cfg.ncol_m1)
            : (idx_q == LW'(c) && LW'(r) <= cfg.nrow_m1));
         assign level  = cfg.rows_drv ? sense[c] : sense[r];
         assign nv     = cfg.pull ? level : ~level;
         assign commit = hit && (nv != status[K]) && (!cfg.cf_en || cf_q >= cfg.cf_sel);
         assign seen   = commit && (nv ? edge_sel[2*K] : edge_sel[2*K+1]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status[K] <= 1'b0;
               flags[K]  <= 1'b0;
               cf_q      <= '0;
            end else begin
               flags[K] <= seen | (flags[K] & ~clr[K]);
               if (commit) begin
                  status[K] <= nv;
                  cf_q      <= '0;
               end else if (hit) begin
                  cf_q <= (nv == status[K]) ? 3'd0 : cf_q + 3'd1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/kmx_scan_ctrl.sv
module kmx_scan_ctrl
   import kmx_pkg::*;
#(
   parameter int unsigned LINES  = 8,
   parameter int unsigned SETTLE = 6,
   parameter int unsigned SYNC   = 2,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [7:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [LINES-1:0] row_in,
   input  logic [LINES-1:0] col_in,
   output logic [LINES-1:0] row_drv_o,
   output logic [LINES-1:0] row_oe_o,
   output logic [LINES-1:0] col_drv_o,
   output logic [LINES-1:0] col_oe_o,
   output logic             irq_o
);
   localparam int unsigned KEYS = LINES * LINES;

   if (LINES != 8) begin : g_bad_lines
      $error("kmx_scan_ctrl: key packing needs LINES == 8");
   end
   if (SEL_W != 3) begin : g_bad_sel
      $error("kmx_scan_ctrl: filter selectors are 3 bits wide");
   end
   if (SYNC < 1 || SETTLE < SYNC + 3) begin : g_bad_settle
      $error("kmx_scan_ctrl: SETTLE must cover the synchronizer");
   end

   kmx_cfg_t          cfg;
   logic [2*KEYS-1:0] edge_sel;
   logic [KEYS-1:0]   mask, clr, status, flags;
   logic [LINES-1:0]  row_sy [SYNC];
   logic [LINES-1:0]  col_sy [SYNC];
   logic [LINES-1:0]  sense_raw, sense;
   logic              scan_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC; s++) begin
            row_sy[s] <= '1;
            col_sy[s] <= '1;
         end
      end else begin
         row_sy[0] <= row_in;
         col_sy[0] <= col_in;
         for (int s = 1; s < SYNC; s++) begin
            row_sy[s] <= row_sy[s-1];
            col_sy[s] <= col_sy[s-1];
         end
      end
   end

   assign sense_raw = cfg.rows_drv ? col_sy[SYNC-1] : row_sy[SYNC-1];
   assign scan_en   = cfg.en;

   kmx_regs #(.KEYS(KEYS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .status(status), .flags(flags),
      .cfg(cfg), .edge_sel(edge_sel), .mask(mask), .clr(clr),
      .row_oe(row_oe_o), .col_oe(col_oe_o)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_filt
      kmx_deglitch #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_flt (
         .clk(clk), .rst_n(rst_n), .en(cfg.lf_en), .sel(cfg.lf_sel),
         .din(sense_raw[l]), .q(sense[l])
      );
   end

   kmx_scanner #(.LINES(LINES), .SETTLE(SETTLE), .CNT_W(CNT_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .sense(sense),
      .edge_sel(edge_sel), .clr(clr), .row_drv(row_drv_o),
      .col_drv(col_drv_o), .status(status), .flags(flags)
   );

   assign irq_o = |(flags & mask);
endmodule

// File: rtl/kmx_scan_ctrl_chk.sv
module kmx_scan_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        en,
   input logic [63:0] status,
   input logic [63:0] flags,
   input logic [63:0] mask,
   input logic [7:0]  row_drv,
   input logic [7:0]  col_drv,
   input logic        irq
);
   a_r6_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{row_drv, col_drv}));

   a_r7_lines_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (&row_drv && &col_drv));

   a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(status));

   a_r8_flag_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & ~$past(flags))) |-> (status != $past(status)));

   a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|mask && |flags));
endmodule

bind kmx_scan_ctrl kmx_scan_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(scan_en), .status(status), .flags(flags),
   .mask(mask), .row_drv(row_drv_o), .col_drv(col_drv_o), .irq(irq_o)
);

// File: tb/kmx_scan_ctrl_tb.sv
`timescale 1ns/1ps
module kmx_scan_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  row_in, col_in, row_drv_o, row_oe_o, col_drv_o, col_oe_o;
   logic        irq_o;
   logic [63:0] pressed = '0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [63:0] exp_st = '0;
   logic [63:0] exp_fl = '0;

   always #2.5 clk = ~clk;

   kmx_scan_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_in(row_in),
      .col_in(col_in), .row_drv_o(row_drv_o), .row_oe_o(row_oe_o),
      .col_drv_o(col_drv_o), .col_oe_o(col_oe_o), .irq_o(irq_o)
   );

   // keypad: a pressed key shorts its row and column; a low driven line pulls the other low
   always_comb begin
      for (int c = 0; c < 8; c++) begin
         col_in[c] = 1'b1;
         for (int r = 0; r < 8; r++)
            if (pressed[r*8+c] && !row_drv_o[r]) col_in[c] = 1'b0;
      end
      for (int r = 0; r < 8; r++) begin
         row_in[r] = 1'b1;
         for (int c = 0; c < 8; c++)
            if (pressed[r*8+c] && !col_drv_o[c]) row_in[r] = 1'b0;
      end
   end

   function automatic logic [31:0] mk_ctrl(input logic en, pull, input int nr, nc,
                                           input logic lfe, input int lfs,
                                           input logic cfe, input int cfs);
      return 32'(en) | (32'(pull) << 1) | (32'(lfs) << 8) | (32'(lfe) << 11) |
             (32'(cfs) << 12) | (32'(cfe) << 15) | (32'(nc - 1) << 16) | (32'(nr - 1) << 20);
   endfunction

   function automatic logic [63:0] f_status(input logic [63:0] old, prs, input logic pull,
                                            input int nr, nc);
      logic [63:0] s = old;
      for (int r = 0; r < nr; r++)
         for (int c = 0; c < nc; c++)
            s[r*8+c] = pull ? ~prs[r*8+c] : prs[r*8+c];
      return s;
   endfunction

   function automatic logic [63:0] f_flags(input logic [63:0] fl, os, ns,
                                           input logic [127:0] em);
      logic [63:0] f = fl;
      for (int k = 0; k < 64; k++)
         if (os[k] != ns[k] && ((ns[k] && em[2*k]) || (!ns[k] && em[2*k+1]))) f[k] = 1'b1;
      return f;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd64(input logic [7:0] a, output logic [63:0] d);
      logic [31:0] lo, hi;
      rd(a, lo);
      rd(a + 8'd4, hi);
      d = {hi, lo};
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic measure_dwell(output int n);
      logic [7:0] prev;
      @(negedge clk);
      prev = row_drv_o;
      while (row_drv_o == prev) @(negedge clk);
      prev = row_drv_o;
      n = 0;
      while (row_drv_o == prev) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      wait_cyc(190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [63:0] q;
      int          n;
      logic        ok;
      void'($urandom(32'd2718));
      wait_cyc(3);
      #1 rst_n = 1'b1;

      // R1: reset state and readback
      rd(8'h80, d); chk("R1 ctrl reset", 64'(d), 64'h0);
      rd(8'h84, d); chk("R1 pin direction reset", 64'(d), 64'h0);
      rd64(8'hA0, q); chk("R1 key state reset", q, 64'h0);
      rd64(8'hC0, q); chk("R1 flags reset", q, 64'h0);
      chk("R1 irq reset", 64'(irq_o), 64'h0);
      chk("R7 lines idle after reset", 64'({row_drv_o, col_drv_o}), 64'hFFFF);
      wr(8'h80, 32'hFFFF_FFFF); rd(8'h80, d);
      chk("R1 ctrl implemented bits", 64'(d), 64'h0077FF03);
      wr(8'h80, 32'h0);
      wr(8'h84, 32'hFFFF_FFFF); rd(8'h84, d);
      chk("R1 pin direction bits", 64'(d), 64'hFFFF0000);
      rd(8'hB8, d); chk("R1 clear reads zero", 64'(d), 64'h0);

      // R13 / R6: dwell and drive pattern, rows driven
      wr(8'h84, 32'hFF00_0000);
      wr(8'h80, mk_ctrl(1, 0, 8, 8, 0, 0, 0, 0));
      measure_dwell(n); chk("R13 dwell without filter", 64'(n), 64'd6);
      ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (col_drv_o != 8'hFF || $countones(~row_drv_o) != 1) ok = 1'b0;
      end
      chk("R6 one low row, columns high", 64'(ok), 64'd1);
      chk("R6 output enables", 64'({row_oe_o, col_oe_o}), 64'hFF00);
      wr(8'h80, mk_ctrl(1, 0, 8, 8, 1, 2, 0, 0));
      measure_dwell(n); measure_dwell(n);
      chk("R13 dwell with filter sel 2", 64'(n), 64'd14);

      // R11: glitch shorter than the line filter window
      wr(8'h80, mk_ctrl(1, 0, 8, 8, 1, 4, 0, 0));
      wait_cyc(400);
      pressed[19] = 1'b1; wait_cyc(20); pressed[19] = 1'b0;
      wait_cyc(700);
      rd64(8'hA0, q); chk("R11 short press filtered", q, 64'h0);
      pressed[19] = 1'b1; wait_cyc(1100);
      rd64(8'hA0, q); chk("R11 long press accepted", q, 64'h1 << 19);
      pressed[19] = 1'b0; wait_cyc(1100);
      rd64(8'hA0, q); chk("R11 release accepted", q, 64'h0);

      // R12: confirmation over consecutive scans (n=3 -> 4 scans of 48 cycles)
      wr(8'h80, mk_ctrl(1, 0, 8, 8, 0, 0, 1, 3));
      wait_cyc(100);
      pressed[5] = 1'b1; wait_cyc(60); pressed[5] = 1'b0;
      wait_cyc(300);
      rd64(8'hA0, q); chk("R12 brief press not confirmed", q, 64'h0);
      pressed[5] = 1'b1; wait_cyc(600);
      rd64(8'hA0, q); chk("R12 steady press confirmed", q, 64'h1 << 5);
      pressed[5] = 1'b0; wait_cyc(600);
      rd64(8'hA0, q); chk("R12 release confirmed", q, 64'h0);

      // R7: disable freezes state and flags
      wr(8'h80, mk_ctrl(1, 0, 8, 8, 0, 0, 0, 0));
      pressed[40] = 1'b1; wait_cyc(200);
      rd64(8'hA0, q); chk("R2 row 5 column 0 in word 1 bit 8", q, 64'h1 << 40);
      wr(8'h80, mk_ctrl(0, 0, 8, 8, 0, 0, 0, 0));
      wr(8'hB8, 32'hFFFF_FFFF); wr(8'hBC, 32'hFFFF_FFFF);
      wr(8'h90, 32'hFFFF_FFFF); wr(8'h94, 32'hFFFF_FFFF);
      wr(8'h98, 32'hFFFF_FFFF); wr(8'h9C, 32'hFFFF_FFFF);
      pressed = '0; wait_cyc(300);
      rd64(8'hA0, q); chk("R7 key state frozen", q, 64'h1 << 40);
      rd64(8'hC0, q); chk("R7 no flags while off", q, 64'h0);
      chk("R7 lines high while off", 64'({row_drv_o, col_drv_o}), 64'hFFFF);
      exp_st = 64'h1 << 40;
      exp_fl = '0;

      // R2 R3 R4 R5 R8 R9 R10: random configurations
      for (int it = 0; it < 24; it++) begin
         logic        rows, pull;
         int          nr, nc;
         logic [127:0] em;
         logic [63:0]  msk, newst, clrv;
         rows  = 1'($urandom);
         pull  = 1'($urandom);
         nr    = 1 + int'($urandom % 8);
         nc    = 1 + int'($urandom % 8);
         if (it < 2) begin nr = 8; nc = 8; end
         em    = {$urandom, $urandom, $urandom, $urandom};
         if (it == 3) em = '0;
         msk   = {$urandom, $urandom};
         if (it == 4) msk = '0;
         wr(8'h80, mk_ctrl(0, pull, nr, nc, 0, 0, 0, 0));
         wr(8'h84, rows ? 32'hFF00_0000 : 32'h00FF_0000);
         wr(8'h90, em[31:0]);  wr(8'h94, em[63:32]);
         wr(8'h98, em[95:64]); wr(8'h9C, em[127:96]);
         wr(8'hB0, msk[31:0]); wr(8'hB4, msk[63:32]);
         pressed = {$urandom, $urandom};
         wr(8'h80, mk_ctrl(1, pull, nr, nc, 0, 0, 0, 0));
         wait_cyc(300);
         newst  = f_status(exp_st, pressed, pull, nr, nc);
         exp_fl = f_flags(exp_fl, exp_st, newst, em);
         exp_st = newst;
         rd64(8'hA0, q);
         if (!rows) chk("R3 key state, columns driven", q, exp_st);
         else if (pull) chk("R4 key state, pull-up mode", q, exp_st);
         else chk("R2 R5 key state, rows driven", q, exp_st);
         rd64(8'hC0, q); chk("R8 flags after edges", q, exp_fl);
         chk("R9 irq", 64'(irq_o), 64'(|(exp_fl & msk)));
         clrv = {$urandom, $urandom};
         wr(8'hB8, clrv[31:0]); wr(8'hBC, clrv[63:32]);
         exp_fl = exp_fl & ~clrv;
         rd64(8'hC0, q); chk("R10 write-one clear", q, exp_fl);
         chk("R9 irq after clear", 64'(irq_o), 64'(|(exp_fl & msk)));
         wr(8'h80, mk_ctrl(0, pull, nr, nc, 0, 0, 0, 0));
      end

      finish_run();
   end
endmodule